// File: doc/BRIEF.md
# Ethernet DMA Control and Status Registers

This block is the software-visible register bank of an Ethernet DMA engine. A host reaches it through a plain memory-mapped bus: a write strobe, a read strobe, a byte address and 32-bit data. The byte address is turned into a word index. A small set of indices have side effects or are held in flops: bus mode, control, interrupt enable, status, the two ring bases, the two current-descriptor pointers, a fixed version word and a transmit poll-demand slot. Every other index below the register window limit is plain storage, held in an inferred block RAM.

The transmit and receive engines report events through a 32-bit set-pulse vector that ORs into the status register. Software clears status bits by writing ones. A single level interrupt follows the masked status. Writing the poll-demand slot emits a one-cycle kick toward the transmit engine. Writing a ring base also restarts the matching current-descriptor pointer. Reads return data one cycle after the request. A read strobe that coincides with a write is not served.

Top module: `edma_csr`

## Requirements
- R1: The word index is the byte address shifted right by two, so the two low address bits select nothing.
- R2: Index 0x008 always reads 0x00001012, and writes to it change nothing.
- R3: Bit 0 of the bus-mode register (index 0x3C0) is stored as zero on every write. All other bits are kept.
- R4: A write to the status register (index 0x3C5) clears every bit where the written word has a one and leaves the other bits unchanged.
- R5: Each bit of `sts_set` ORs into status on the clock edge where it is high. When a set and a software clear of the same bit fall in one cycle, the bit ends set.
- R6: A write to the receive ring base (0x3C3) or transmit ring base (0x3C4) also loads the same value into the current receive (0x3D3) or transmit (0x3D2) descriptor pointer. The pointers can also be written directly.
- R7: `irq` is high exactly when status AND interrupt enable (index 0x3C7) is nonzero, and it reflects the state left by each clock edge.
- R8: A write to index 0x3C1 drives `tx_kick` high for the one cycle after the write edge. The value is not stored, and the index reads zero.
- R9: Indices at or above 0x400 read as zero, and writes to them alter no register or storage word.
- R10: Any other index below 0x400 stores the written word and returns it on read.
- R11: `rx_enable` follows control-register (index 0x3C6) bit 1, and `tx_start` follows control bit 13.
- R12: After reset, every register is zero and `irq`, `tx_kick` and `bus_rvalid` are low.
- R13: A read accepted on one edge returns its data with `bus_rvalid` high during the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe, ignored when bus_wr is high |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid |
| sts_set | input | 32 | Status set pulses from the engines |
| irq | output | 1 | Level interrupt |
| tx_kick | output | 1 | Transmit poll-demand pulse |
| rx_enable | output | 1 | Receive enable from control |
| tx_start | output | 1 | Transmit start from control |
| cur_rx_desc | output | 32 | Current receive descriptor pointer |
| cur_tx_desc | output | 32 | Current transmit descriptor pointer |

## Verification
The status register has two writers: the engines' set pulses and software's write-one-to-clear. Both can act on the same bit in the same cycle. The bench drives a status write together with a set pulse, once on the very bit being cleared and once on a different bit. It then reads status back through the bus and expects the set bit to survive, the cleared bit to drop, and `irq` to follow the surviving enabled bits.

// File: rtl/edma_csr_pkg.sv
package edma_csr_pkg;

  localparam int unsigned DATA_W = 32;
  localparam logic [DATA_W-1:0] VERSION_WORD = 32'h0000_1012;

  // word indices with side effects or flop storage
  localparam int unsigned IDX_VERSION = 32'h008;
  localparam int unsigned IDX_BUSMODE = 32'h3C0;
  localparam int unsigned IDX_TXPOLL  = 32'h3C1;
  localparam int unsigned IDX_RXBASE  = 32'h3C3;
  localparam int unsigned IDX_TXBASE  = 32'h3C4;
  localparam int unsigned IDX_STATUS  = 32'h3C5;
  localparam int unsigned IDX_CTRL    = 32'h3C6;
  localparam int unsigned IDX_INTEN   = 32'h3C7;
  localparam int unsigned IDX_CURTX   = 32'h3D2;
  localparam int unsigned IDX_CURRX   = 32'h3D3;
  localparam int unsigned IDX_LIMIT   = 32'h400;

  // control bit positions
  localparam int unsigned CTRL_RX_EN_BIT = 1;
  localparam int unsigned CTRL_TX_GO_BIT = 13;

  // status bit positions used by the engines
  localparam int unsigned ST_TX_DONE  = 0;
  localparam int unsigned ST_TX_UNAV  = 2;
  localparam int unsigned ST_RX_DONE  = 6;
  localparam int unsigned ST_RX_UNAV  = 7;
  localparam int unsigned ST_ABNORMAL = 15;
  localparam int unsigned ST_NORMAL   = 16;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_RAM,
    SEL_VERSION,
    SEL_BUSMODE,
    SEL_TXPOLL,
    SEL_RXBASE,
    SEL_TXBASE,
    SEL_STATUS,
    SEL_CTRL,
    SEL_INTEN,
    SEL_CURTX,
    SEL_CURRX
  } csr_sel_e;

endpackage

// File: rtl/edma_csr_decode.sv
module edma_csr_decode
  import edma_csr_pkg::*;
#(
  parameter int unsigned IDX_W = 11
) (
  input  logic [IDX_W-1:0] idx,
  output csr_sel_e         sel
);

  logic [31:0] idx32;
  assign idx32 = 32'(idx);

  always_comb begin
    if (idx32 >= IDX_LIMIT)        sel = SEL_NONE;
    else if (idx32 == IDX_VERSION) sel = SEL_VERSION;
    else if (idx32 == IDX_BUSMODE) sel = SEL_BUSMODE;
    else if (idx32 == IDX_TXPOLL)  sel = SEL_TXPOLL;
    else if (idx32 == IDX_RXBASE)  sel = SEL_RXBASE;
    else if (idx32 == IDX_TXBASE)  sel = SEL_TXBASE;
    else if (idx32 == IDX_STATUS)  sel = SEL_STATUS;
    else if (idx32 == IDX_CTRL)    sel = SEL_CTRL;
    else if (idx32 == IDX_INTEN)   sel = SEL_INTEN;
    else if (idx32 == IDX_CURTX)   sel = SEL_CURTX;
    else if (idx32 == IDX_CURRX)   sel = SEL_CURRX;
    else                           sel = SEL_RAM;
  end

endmodule

// File: rtl/edma_csr_store.sv
module edma_csr_store #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // single port, read-first: maps onto one block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

endmodule

// File: rtl/edma_csr_status.sv
module edma_csr_status #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_en,
  input  logic [W-1:0] clr_mask,
  input  logic [W-1:0] set_mask,
  output logic [W-1:0] status_q,
  output logic [W-1:0] status_d
);

  // engine set pulses win over a software clear of the same bit
  always_comb begin
    if (clr_en) status_d = (status_q & ~clr_mask) | set_mask;
    else        status_d = status_q | set_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= status_d;
  end

  a_r4_w1c_clears: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> ((status_q & $past(clr_mask & ~set_mask)) == '0));

  a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
    (|set_mask) |=> ((status_q & $past(set_mask)) == $past(set_mask)));

  a_r4_untouched_kept: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> ((status_q & $past(status_q & ~clr_mask)) == $past(status_q & ~clr_mask)));

endmodule

// File: rtl/edma_csr.sv
module edma_csr
  import edma_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  localparam int unsigned IDX_W = ADDR_W - 2,
  localparam int unsigned RAM_AW = $clog2(IDX_LIMIT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic [31:0]       sts_set,
  output logic              irq,
  output logic              tx_kick,
  output logic              rx_enable,
  output logic              tx_start,
  output logic [31:0]       cur_rx_desc,
  output logic [31:0]       cur_tx_desc
);

  logic [IDX_W-1:0] idx;
  logic             unused_lsb;
  csr_sel_e         sel;
  csr_sel_e         rsel_q;

  assign idx        = bus_addr[ADDR_W-1:2];
  assign unused_lsb = ^bus_addr[1:0];

  edma_csr_decode #(.IDX_W(IDX_W)) u_dec (
    .idx (idx),
    .sel (sel)
  );

  logic rd_go;
  logic wr_hit_ram;
  assign rd_go      = bus_rd & ~bus_wr;
  assign wr_hit_ram = bus_wr & (sel == SEL_RAM);

  logic [DATA_W-1:0] ram_q;
  edma_csr_store #(.DEPTH(IDX_LIMIT), .DW(DATA_W)) u_store (
    .clk   (clk),
    .we    (wr_hit_ram),
    .addr  (idx[RAM_AW-1:0]),
    .wdata (bus_wdata),
    .rdata (ram_q)
  );

  logic [DATA_W-1:0] busmode_q, ctrl_q, inten_q;
  logic [DATA_W-1:0] rxbase_q, txbase_q, currx_q, curtx_q;
  logic [DATA_W-1:0] inten_d;
  logic [DATA_W-1:0] status_q, status_d;
  logic              sts_clr;

  assign sts_clr = bus_wr & (sel == SEL_STATUS);
  assign inten_d = (bus_wr && sel == SEL_INTEN) ? bus_wdata : inten_q;

  edma_csr_status #(.W(DATA_W)) u_status (
    .clk      (clk),
    .rst      (rst),
    .clr_en   (sts_clr),
    .clr_mask (bus_wdata),
    .set_mask (sts_set),
    .status_q (status_q),
    .status_d (status_d)
  );

  // flop registers with write side effects
  always_ff @(posedge clk) begin
    if (rst) begin
      busmode_q <= '0;
      ctrl_q    <= '0;
      inten_q   <= '0;
      rxbase_q  <= '0;
      txbase_q  <= '0;
      currx_q   <= '0;
      curtx_q   <= '0;
    end else begin
      inten_q <= inten_d;
      if (bus_wr) begin
        unique case (sel)
          SEL_BUSMODE: busmode_q <= {bus_wdata[DATA_W-1:1], 1'b0};
          SEL_CTRL:    ctrl_q    <= bus_wdata;
          SEL_RXBASE: begin
            rxbase_q <= bus_wdata;
            currx_q  <= bus_wdata;
          end
          SEL_TXBASE: begin
            txbase_q <= bus_wdata;
            curtx_q  <= bus_wdata;
          end
          SEL_CURRX:   currx_q   <= bus_wdata;
          SEL_CURTX:   curtx_q   <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= 1'b0;
      tx_kick <= 1'b0;
    end else begin
      irq     <= |(status_d & inten_d);
      tx_kick <= bus_wr & (sel == SEL_TXPOLL);
    end
  end

  // read path: flop registers are captured on the request edge,
  // storage words come out of the RAM on the same edge
  logic [DATA_W-1:0] flop_rd_q;
  logic [DATA_W-1:0] flop_rd_d;

  always_comb begin
    unique case (sel)
      SEL_VERSION: flop_rd_d = VERSION_WORD;
      SEL_BUSMODE: flop_rd_d = busmode_q;
      SEL_RXBASE:  flop_rd_d = rxbase_q;
      SEL_TXBASE:  flop_rd_d = txbase_q;
      SEL_STATUS:  flop_rd_d = status_q;
      SEL_CTRL:    flop_rd_d = ctrl_q;
      SEL_INTEN:   flop_rd_d = inten_q;
      SEL_CURRX:   flop_rd_d = currx_q;
      SEL_CURTX:   flop_rd_d = curtx_q;
      default:     flop_rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      rsel_q     <= SEL_NONE;
      flop_rd_q  <= '0;
    end else begin
      bus_rvalid <= rd_go;
      if (rd_go) begin
        rsel_q    <= sel;
        flop_rd_q <= flop_rd_d;
      end
    end
  end

  assign bus_rdata   = (rsel_q == SEL_RAM) ? ram_q : flop_rd_q;
  assign rx_enable   = ctrl_q[CTRL_RX_EN_BIT];
  assign tx_start    = ctrl_q[CTRL_TX_GO_BIT];
  assign cur_rx_desc = currx_q;
  assign cur_tx_desc = curtx_q;

  a_r7_irq_tracks: assert property (@(posedge clk) disable iff (rst)
    irq == |(status_q & inten_q));

  a_r6_rx_reload: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel == SEL_RXBASE) |=> (cur_rx_desc == rxbase_q));

  a_r6_tx_reload: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel == SEL_TXBASE) |=> (cur_tx_desc == txbase_q));

  a_r8_kick_cause: assert property (@(posedge clk) disable iff (rst)
    tx_kick |-> $past(bus_wr && sel == SEL_TXPOLL));

  a_r9_high_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_go && sel == SEL_NONE) |=> (bus_rdata == '0));

  a_r13_valid_follows: assert property (@(posedge clk) disable iff (rst)
    rd_go |=> bus_rvalid);

  a_r3_busmode_lsb: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel == SEL_BUSMODE) |=> (busmode_q[0] == 1'b0));

endmodule

// File: tb/edma_csr_test.sv
`timescale 1ns/1ps
module edma_csr_test;

  localparam int ADDR_W = 13;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              bus_rvalid;
  logic [31:0]       sts_set = '0;
  logic              irq, tx_kick, rx_enable, tx_start;
  logic [31:0]       cur_rx_desc, cur_tx_desc;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  edma_csr #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .sts_set(sts_set), .irq(irq),
    .tx_kick(tx_kick), .rx_enable(rx_enable), .tx_start(tx_start),
    .cur_rx_desc(cur_rx_desc), .cur_tx_desc(cur_tx_desc)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as read data comes out
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check("R13 unexpected read data", 32'd1, 32'd0);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                    input logic [31:0] set = 32'h0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; sts_set = set;
    @(negedge clk);
    bus_wr = 1'b0; sts_set = '0;
  endtask

  task automatic pulse(input logic [31:0] set);
    @(negedge clk);
    sts_set = set;
    @(negedge clk);
    sts_set = '0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial begin
    #500000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    check("R12 irq", {31'b0, irq}, 32'd0);
    check("R12 tx_kick", {31'b0, tx_kick}, 32'd0);
    check("R12 rvalid", {31'b0, bus_rvalid}, 32'd0);
    check("R12 rx_enable", {31'b0, rx_enable}, 32'd0);
    rd(13'hF14, 32'h0, "R12 status");
    rd(13'hF4C, 32'h0, "R12 cur rx");

    // R2 version
    rd(13'h020, 32'h1012, "R2 version");
    wr(13'h020, 32'hFFFF_FFFF);
    rd(13'h020, 32'h1012, "R2 version after write");

    // R3 bus mode bit 0
    wr(13'hF00, 32'hABCD_0001);
    rd(13'hF00, 32'hABCD_0000, "R3 bus mode");
    // R1 low address bits ignored
    wr(13'hF03, 32'h0000_0055);
    rd(13'hF02, 32'h0000_0054, "R1 word index");

    // R10 plain storage
    wr(13'h040, 32'h1234_5678);
    wr(13'hFFC, 32'h0000_CAFE);
    wr(13'h000, 32'h0000_0011);
    rd(13'h040, 32'h1234_5678, "R10 store low");
    rd(13'hFFC, 32'h0000_CAFE, "R10 store top");

    // R9 out of window
    wr(13'h1000, 32'hDEAD_BEEF);
    rd(13'h1000, 32'h0, "R9 high read");
    rd(13'h1FFC, 32'h0, "R9 top read");
    rd(13'h000, 32'h0000_0011, "R9 no alias write");

    // R6 ring base reload
    wr(13'hF0C, 32'h8000_0100);
    check("R6 cur rx port", cur_rx_desc, 32'h8000_0100);
    rd(13'hF4C, 32'h8000_0100, "R6 cur rx read");
    wr(13'hF10, 32'h4000_0200);
    check("R6 cur tx port", cur_tx_desc, 32'h4000_0200);
    wr(13'hF48, 32'h0000_0044);
    rd(13'hF48, 32'h0000_0044, "R6 cur tx direct");
    rd(13'hF10, 32'h4000_0200, "R6 tx base kept");

    // R11 control outputs
    wr(13'hF18, 32'h0000_2002);
    check("R11 rx_enable", {31'b0, rx_enable}, 32'd1);
    check("R11 tx_start", {31'b0, tx_start}, 32'd1);
    check("R8 no kick on ctrl", {31'b0, tx_kick}, 32'd0);
    wr(13'hF18, 32'h0000_0002);
    check("R11 tx_start off", {31'b0, tx_start}, 32'd0);

    // R8 poll demand
    wr(13'hF04, 32'h0000_0001);
    check("R8 kick high", {31'b0, tx_kick}, 32'd1);
    @(negedge clk);
    check("R8 kick one cycle", {31'b0, tx_kick}, 32'd0);
    rd(13'hF04, 32'h0, "R8 not stored");

    // R7 / R4 / R5 status and interrupt
    wr(13'hF1C, 32'h0000_0041);
    check("R7 irq idle", {31'b0, irq}, 32'd0);
    pulse(32'h0000_0001);
    check("R7 irq on enabled bit", {31'b0, irq}, 32'd1);
    pulse(32'h0001_0000);
    rd(13'hF14, 32'h0001_0001, "R5 sets accumulate");
    wr(13'hF14, 32'h0000_0001);
    check("R7 irq after clear", {31'b0, irq}, 32'd0);
    rd(13'hF14, 32'h0001_0000, "R4 clear only ones");
    wr(13'hF14, 32'h0001_0000, 32'h0001_0040);
    check("R7 irq on rx done", {31'b0, irq}, 32'd1);
    rd(13'hF14, 32'h0001_0040, "R5 set wins over clear");
    wr(13'hF14, 32'h0000_0040, 32'h0000_0004);
    rd(13'hF14, 32'h0001_0004, "R5 clear other bit same cycle");
    check("R7 irq masked bits", {31'b0, irq}, 32'd0);
    wr(13'hF1C, 32'h0000_0004);
    check("R7 irq on enable write", {31'b0, irq}, 32'd1);
    wr(13'hF14, 32'hFFFF_FFFF);
    check("R7 irq all cleared", {31'b0, irq}, 32'd0);
    rd(13'hF14, 32'h0, "R4 clear all");

    repeat (3) @(negedge clk);
    check("R13 scoreboard drained", exp_q.size(), 32'd0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule